// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Sequencer

This block is the timing core of a master-mode SPI controller. It divides the system clock down to the serial clock and decides when each chip-select line is active. It also emits one-cycle strobes that tell a separate shift engine when to capture a received bit and when to present the next transmitted bit. The shift engine asks for a frame with a request pulse. It ends the frame with a done pulse once it has seen its last capture strobe. The sequencer then closes the frame according to the chip-select policy in force.

Configuration arrives on plain input ports:

- a 12-bit clock divisor;
- a two-bit clock mode, with bit 0 as phase and bit 1 as polarity;
- a chip-select index;
- a chip-select policy: 0 or 1 for per-frame auto, 2 for hold, 3 for off;
- four 8-bit delays, counted in serial-clock periods: select-to-first-edge, last-edge-to-release, minimum deselect time, and the gap between frames while the line stays selected.

The per-line inactive levels are kept in a small register with its own write strobe. Reading it back shows only the implemented lines. After software writes all ones, the readback therefore gives the line count.

The controller has seven states:

- ST_IDLE: waits for a request.
- ST_LEAD: the line is selected and the select-to-clock delay runs.
- ST_SHIFT: the serial clock toggles.
- ST_TRAIL: the clock-to-release delay runs.
- ST_REST: the line is deselected and the minimum inactive time runs.
- ST_GAP: the inter-frame gap runs in hold policy.
- ST_HOLD: the line stays selected and the controller waits.

The transitions are:

- ST_IDLE→ST_LEAD on a request.
- ST_LEAD→ST_SHIFT when the delay expires.
- ST_SHIFT→ST_TRAIL, or ST_SHIFT→ST_GAP in hold policy, on a half-period tick where the clock is at rest and done has been seen.
- ST_TRAIL→ST_REST when its delay expires.
- ST_REST→ST_IDLE when its delay expires.
- ST_GAP→ST_HOLD when its delay expires.
- ST_HOLD→ST_TRAIL when the policy leaves hold.
- ST_HOLD→ST_SHIFT on a request.

Top module: `spi_sck_cs_seq`

## Requirements
- R1: After reset, `sck` is low, every `cs_lines` bit is 1, both strobes are low, and `idle_rdata` reads 0x0000000F (NUM_CS=4).
- R2: While a frame shifts, `sck` changes level every `cfg_div`+1 clock cycles, which gives a serial clock of f/(2·(`cfg_div`+1)).
- R3: Outside ST_SHIFT, `sck` copies `cfg_clk_mode[1]` one cycle after that bit changes.
- R4: Each `sck` edge comes with exactly one strobe in the cycle the new level appears. With `cfg_clk_mode[0]`=0, leading edges (away from rest) carry `sample_stb` and trailing edges carry `launch_stb`. With `cfg_clk_mode[0]`=1 the roles swap. A frame of N done-terminated bits has 2N edges.
- R5: Under auto policy (0 or 1), the selected line goes active on the cycle after a request. The first `sck` edge follows (2·`cfg_dly_cs_sck`+2)·(`cfg_div`+1) cycles later. The line is released (2·`cfg_dly_sck_cs`+2)·(`cfg_div`+1) cycles after the last edge.
- R6: If a request is pending when a frame ends under auto policy, the line is inactive for exactly (2·`cfg_dly_inter_cs`+1)·(`cfg_div`+1)+1 cycles before it is selected again.
- R7: Under hold policy (2), the line stays active between frames. A pending request's first edge comes (2·`cfg_dly_frame_gap`+3)·(`cfg_div`+1)+1 cycles after the previous frame's last edge.
- R8: In ST_HOLD, changing the policy away from 2 releases the line (2·`cfg_dly_sck_cs`+1)·(`cfg_div`+1) cycles after the first clock edge that samples the new policy.
- R9: Under off policy (3), frames still clock and strobe, but no `cs_lines` bit leaves its inactive level.
- R10: At most one line differs from its inactive level. That line is the one numbered `cfg_cs_id`, driven to the inverse of its inactive bit. An index of NUM_CS or more selects no line.
- R11: A pulse on `idle_we` stores `idle_wdata[NUM_CS-1:0]` as the inactive levels. `idle_rdata` returns them with every higher bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Half-period divisor minus one |
| cfg_clk_mode | input | 2 | Bit 0 phase, bit 1 polarity |
| cfg_cs_id | input | ID_W | Index of the line to select |
| cfg_cs_mode | input | 2 | Policy: 0/1 auto, 2 hold, 3 off |
| cfg_dly_cs_sck | input | DLY_W | Select-to-first-edge delay, serial periods |
| cfg_dly_sck_cs | input | DLY_W | Last-edge-to-release delay, serial periods |
| cfg_dly_inter_cs | input | DLY_W | Minimum deselect time, serial periods |
| cfg_dly_frame_gap | input | DLY_W | Inter-frame gap in hold policy, serial periods |
| idle_we | input | 1 | Write strobe for the inactive-level register |
| idle_wdata | input | REG_W | Inactive-level write data |
| idle_rdata | output | REG_W | Inactive-level readback, implemented lines only |
| frame_req | input | 1 | Frame request pulse, latched until taken |
| frame_done | input | 1 | Last-bit pulse from the shift engine, latched |
| sck | output | 1 | Serial clock |
| cs_lines | output | NUM_CS | Chip-select lines |
| sample_stb | output | 1 | Capture strobe |
| launch_stb | output | 1 | Present-next-bit strobe |

## Verification
The bench checks the hold policy across two frames. It also checks a back-to-back request in auto policy, where an early request must wait out the whole minimum deselect time. A design that reused the select-to-clock delay here, or dropped the one-cycle pickup from ST_IDLE, would move the measured gaps by whole tick periods or one cycle. The release from hold is timed from the policy change: a design that released at once or skipped the trailing delay would show the line going high too early. Off policy and an out-of-range index are run with full frames, and any chip-select movement fails. An inactive-level pattern with a mix of ones and zeros shows up a design that assumes active-low lines.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_REST,
        ST_GAP,
        ST_HOLD
    } seq_state_t;

    localparam logic [1:0] CSM_HOLD = 2'd2;
    localparam logic [1:0] CSM_OFF  = 2'd3;

endpackage

// File: rtl/spi_seq_tick.sv
// Half-period tick generator: one pulse every div+1 cycles, restartable.
module spi_seq_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = !clear && (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_seq_delay.sv
// Tick-driven countdown shared by all delay states.
module spi_seq_delay #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/spi_seq_csdrv.sv
// Inactive-level register and per-line chip-select drive.
module spi_seq_csdrv #(
    parameter int NUM_CS = 4,
    parameter int ID_W   = 5,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_we,
    input  logic [REG_W-1:0]  idle_wdata,
    output logic [REG_W-1:0]  idle_rdata,
    input  logic [ID_W-1:0]   cs_id,
    input  logic              drive_en,
    output logic [NUM_CS-1:0] cs_lines
);
    logic [NUM_CS-1:0] lvl_q;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^idle_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '1;
        end else if (idle_we) begin
            lvl_q <= idle_wdata[NUM_CS-1:0];
        end
    end

    generate
        if (REG_W > NUM_CS) begin : g_pad
            assign idle_rdata = {{(REG_W-NUM_CS){1'b0}}, lvl_q};
        end else begin : g_full
            assign idle_rdata = lvl_q[REG_W-1:0];
        end
    endgenerate

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_lines[i] = lvl_q[i] ^ (drive_en && (cs_id == ID_W'(i)));
    end
endmodule

// File: rtl/spi_sck_cs_seq.sv
module spi_sck_cs_seq
    import spi_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 12,
    parameter int DLY_W  = 8,
    parameter int ID_W   = 5,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_clk_mode,
    input  logic [ID_W-1:0]   cfg_cs_id,
    input  logic [1:0]        cfg_cs_mode,
    input  logic [DLY_W-1:0]  cfg_dly_cs_sck,
    input  logic [DLY_W-1:0]  cfg_dly_sck_cs,
    input  logic [DLY_W-1:0]  cfg_dly_inter_cs,
    input  logic [DLY_W-1:0]  cfg_dly_frame_gap,
    input  logic              idle_we,
    input  logic [REG_W-1:0]  idle_wdata,
    output logic [REG_W-1:0]  idle_rdata,
    input  logic              frame_req,
    input  logic              frame_done,
    output logic              sck,
    output logic [NUM_CS-1:0] cs_lines,
    output logic              sample_stb,
    output logic              launch_stb
);
    localparam int CNT_W = DLY_W + 1;

    seq_state_t       state_q, state_d;
    logic             req_pend_q, done_pend_q;
    logic             sck_q, smp_q, lch_q;
    logic             tick, dly_exp, dly_load, flip;
    logic [CNT_W-1:0] dly_val;
    logic             pha, pol, hold_pol, start, end_seen, at_rest;
    logic             in_shift, in_hold, consume, drive_en;

    assign pha      = cfg_clk_mode[0];
    assign pol      = cfg_clk_mode[1];
    assign hold_pol = (cfg_cs_mode == CSM_HOLD);
    assign start    = frame_req | req_pend_q;
    assign end_seen = frame_done | done_pend_q;
    assign at_rest  = (sck_q == pol);
    assign in_shift = (state_q == ST_SHIFT);
    assign in_hold  = (state_q == ST_HOLD);
    assign consume  = start && ((state_q == ST_IDLE) || (in_hold && hold_pol));
    assign drive_en = (state_q != ST_IDLE) && (state_q != ST_REST) && (cfg_cs_mode != CSM_OFF);

    spi_seq_tick #(.DIV_W(DIV_W)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear ((state_q == ST_IDLE) || in_hold),
        .div   (cfg_div),
        .tick  (tick)
    );

    spi_seq_delay #(.CNT_W(CNT_W)) dly_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .tick     (tick),
        .expired  (dly_exp)
    );

    spi_seq_csdrv #(.NUM_CS(NUM_CS), .ID_W(ID_W), .REG_W(REG_W)) cs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_we    (idle_we),
        .idle_wdata (idle_wdata),
        .idle_rdata (idle_rdata),
        .cs_id      (cfg_cs_id),
        .drive_en   (drive_en),
        .cs_lines   (cs_lines)
    );

    // Next-state logic; each delay state lasts 2*delay+1 half periods.
    always_comb begin
        state_d  = state_q;
        dly_load = 1'b0;
        dly_val  = '0;
        flip     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_LEAD;
                    dly_load = 1'b1;
                    dly_val  = {cfg_dly_cs_sck, 1'b0};
                end
            end
            ST_LEAD: begin
                if (tick && dly_exp) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (at_rest && end_seen) begin
                        dly_load = 1'b1;
                        if (hold_pol) begin
                            state_d = ST_GAP;
                            dly_val = {cfg_dly_frame_gap, 1'b0};
                        end else begin
                            state_d = ST_TRAIL;
                            dly_val = {cfg_dly_sck_cs, 1'b0};
                        end
                    end else begin
                        flip = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick && dly_exp) begin
                    state_d  = ST_REST;
                    dly_load = 1'b1;
                    dly_val  = {cfg_dly_inter_cs, 1'b0};
                end
            end
            ST_REST: begin
                if (tick && dly_exp) state_d = ST_IDLE;
            end
            ST_GAP: begin
                if (tick && dly_exp) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!hold_pol) begin
                    state_d  = ST_TRAIL;
                    dly_load = 1'b1;
                    dly_val  = {cfg_dly_sck_cs, 1'b0};
                end else if (start) begin
                    state_d = ST_SHIFT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_pend_q  <= 1'b0;
            done_pend_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            req_pend_q  <= consume ? 1'b0 : (req_pend_q | frame_req);
            done_pend_q <= (in_shift && state_d == ST_SHIFT) ? (done_pend_q | frame_done) : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            smp_q <= 1'b0;
            lch_q <= 1'b0;
        end else begin
            smp_q <= flip && (at_rest ^ pha);
            lch_q <= flip && !(at_rest ^ pha);
            if (!in_shift) begin
                sck_q <= pol;
            end else if (flip) begin
                sck_q <= ~sck_q;
            end
        end
    end

    assign sck        = sck_q;
    assign sample_stb = smp_q;
    assign launch_stb = lch_q;
endmodule

// File: rtl/spi_sck_cs_seq_chk.sv
module spi_sck_cs_seq_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              pol,
    input logic [NUM_CS-1:0] cs_lines,
    input logic [NUM_CS-1:0] idle_lvl,
    input logic [1:0]        cs_mode,
    input logic              sample_stb,
    input logic              launch_stb,
    input logic              in_shift,
    input logic              in_hold
);
    // R3: clock rests at the polarity level outside shifting
    p_rest_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_shift && !$past(in_shift)) |-> (sck == $past(pol)));

    // R4: every strobe marks a level change of the serial clock
    p_strobe_moves_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || launch_stb) |-> (sck != $past(sck)));

    // R4: never both strobes at once
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && launch_stb));

    // R7: resuming from hold leaves chip-select untouched
    p_hold_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_hold) && in_shift) |-> $stable(cs_lines));

    // R9: off policy keeps every line inactive
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode == 2'd3) |-> (cs_lines == idle_lvl));

    // R10: at most one line away from its inactive level
    p_single_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_lines ^ idle_lvl) <= 1);
endmodule

bind spi_sck_cs_seq spi_sck_cs_seq_chk #(.NUM_CS(NUM_CS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .pol        (cfg_clk_mode[1]),
    .cs_lines   (cs_lines),
    .idle_lvl   (idle_rdata[NUM_CS-1:0]),
    .cs_mode    (cfg_cs_mode),
    .sample_stb (sample_stb),
    .launch_stb (launch_stb),
    .in_shift   (in_shift),
    .in_hold    (in_hold)
);

// File: tb/spi_sck_cs_seq_tb_top.sv
module spi_sck_cs_seq_tb_top;
    localparam int EV_CS  = 0;
    localparam int EV_SMP = 1;
    localparam int EV_LCH = 2;

    typedef struct {
        int    kind;
        int    data;
        int    gap;
        int    abs_t;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_div = 12'd1;
    logic [1:0]  cfg_clk_mode = 2'b00;
    logic [4:0]  cfg_cs_id = 5'd0;
    logic [1:0]  cfg_cs_mode = 2'd0;
    logic [7:0]  cfg_dly_cs_sck = 8'd1;
    logic [7:0]  cfg_dly_sck_cs = 8'd1;
    logic [7:0]  cfg_dly_inter_cs = 8'd1;
    logic [7:0]  cfg_dly_frame_gap = 8'd0;
    logic        idle_we = 1'b0;
    logic [31:0] idle_wdata = 32'd0;
    logic [31:0] idle_rdata;
    logic        frame_req = 1'b0;
    logic        frame_done = 1'b0;
    logic        sck;
    logic [3:0]  cs_lines;
    logic        sample_stb, launch_stb;

    exp_t q[$];
    int   total = 0, bad = 0;
    int   cyc = 0, last_cyc = 0;
    int   nb_target = 2, smp_cnt = 0, frames_done = 0;
    logic [3:0] cs_prev = 4'hF;
    bit   finished = 0;

    always #2 clk = ~clk;  // 250 MHz

    spi_sck_cs_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_clk_mode(cfg_clk_mode),
        .cfg_cs_id(cfg_cs_id), .cfg_cs_mode(cfg_cs_mode),
        .cfg_dly_cs_sck(cfg_dly_cs_sck), .cfg_dly_sck_cs(cfg_dly_sck_cs),
        .cfg_dly_inter_cs(cfg_dly_inter_cs), .cfg_dly_frame_gap(cfg_dly_frame_gap),
        .idle_we(idle_we), .idle_wdata(idle_wdata), .idle_rdata(idle_rdata),
        .frame_req(frame_req), .frame_done(frame_done), .sck(sck),
        .cs_lines(cs_lines), .sample_stb(sample_stb), .launch_stb(launch_stb)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic push(input int k, input int d, input int g, input int a, input string tag);
        exp_t e;
        e.kind = k; e.data = d; e.gap = g; e.abs_t = a; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic push_edges(input int nb, input int p, input int pha, input int pol,
                              input int first_gap, input string first_tag);
        for (int e = 0; e < 2 * nb; e++) begin
            int lead = (e % 2 == 0) ? 1 : 0;
            int kind = ((lead ^ pha) != 0) ? EV_SMP : EV_LCH;
            int lvl  = (lead != 0) ? (1 - pol) : pol;
            push(kind, lvl, (e == 0) ? first_gap : p, -1, (e == 0) ? first_tag : "R2/R4");
        end
    endtask

    // Monitor: turns port activity into events and pops the scoreboard.
    task automatic emit(input int k, input int d);
        exp_t e;
        if (q.size() == 0) begin
            chk(0, "unexpected event", k * 256 + d, -1);
        end else begin
            e = q.pop_front();
            chk(k == e.kind && d == e.data, e.tag, k * 256 + d, e.kind * 256 + e.data);
            if (e.gap >= 0) chk(cyc - last_cyc == e.gap, e.tag, cyc - last_cyc, e.gap);
            if (e.abs_t >= 0) chk(cyc == e.abs_t, e.tag, cyc, e.abs_t);
        end
        last_cyc = cyc;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_lines != cs_prev) emit(EV_CS, int'(cs_lines));
            if (sample_stb) emit(EV_SMP, int'(sck));
            if (launch_stb) emit(EV_LCH, int'(sck));
            cs_prev = cs_lines;
        end
    end

    // Shift-engine model: pulses done after the last capture strobe.
    always @(negedge clk) begin
        if (frame_done) frame_done = 1'b0;
        if (rst_n && sample_stb) begin
            smp_cnt++;
            if (smp_cnt == nb_target) begin
                frame_done = 1'b1;
                smp_cnt = 0;
                frames_done++;
            end
        end
    end

    task automatic pulse_req;
        @(negedge clk) frame_req = 1'b1;
        @(negedge clk) frame_req = 1'b0;
    endtask

    task automatic write_idle(input logic [31:0] v);
        @(negedge clk) begin idle_wdata = v; idle_we = 1'b1; end
        @(negedge clk) idle_we = 1'b0;
    endtask

    task automatic drain(input int extra);
        wait (q.size() == 0);
        repeat (extra) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sck == 1'b0, "R1", int'(sck), 0);
        chk(cs_lines == 4'hF, "R1", int'(cs_lines), 15);
        chk(sample_stb == 1'b0, "R1", int'(sample_stb), 0);
        chk(launch_stb == 1'b0, "R1", int'(launch_stb), 0);
        chk(idle_rdata == 32'hF, "R1", int'(idle_rdata), 15);

        // R11 inactive-level register and line discovery
        write_idle(32'hFFFF_FFFF);
        @(negedge clk);
        chk(idle_rdata == 32'h0000_000F, "R11", int'(idle_rdata), 15);
        push(EV_CS, 5, -1, -1, "R11");
        write_idle(32'hA5A5_A5A5 & 32'hFFFF_FFF5);
        @(negedge clk);
        chk(idle_rdata == 32'h0000_0005, "R11", int'(idle_rdata), 5);
        drain(2);

        // R5/R10 auto frame, mixed inactive levels, line 1 active-high
        cfg_div = 12'd1; cfg_cs_id = 5'd1; cfg_cs_mode = 2'd0;
        nb_target = 2;
        push(EV_CS, 7, -1, -1, "R10");
        push_edges(2, 2, 0, 0, 8, "R5");
        push(EV_CS, 5, 8, -1, "R5");
        base = frames_done;
        pulse_req();
        wait (frames_done == base + 1);
        drain(12);
        push(EV_CS, 15, -1, -1, "R11");
        write_idle(32'h0000_000F);
        drain(2);

        // R3 idle level follows polarity
        cfg_clk_mode = 2'b11;
        repeat (2) @(negedge clk);
        chk(sck == 1'b1, "R3", int'(sck), 1);

        // R6 back-to-back auto frames, phase 1, polarity 1
        cfg_div = 12'd2; cfg_dly_cs_sck = 8'd0; cfg_dly_sck_cs = 8'd2;
        cfg_dly_inter_cs = 8'd2; cfg_cs_id = 5'd3;
        push(EV_CS, 7, -1, -1, "R10");
        push_edges(2, 3, 1, 1, 6, "R5");
        push(EV_CS, 15, 18, -1, "R5");
        push(EV_CS, 7, 16, -1, "R6");
        push_edges(2, 3, 1, 1, 6, "R5");
        push(EV_CS, 15, 18, -1, "R5");
        base = frames_done;
        pulse_req();
        wait (frames_done == base + 1);
        pulse_req();
        wait (frames_done == base + 2);
        drain(25);
        cfg_clk_mode = 2'b00;
        repeat (2) @(negedge clk);
        chk(sck == 1'b0, "R3", int'(sck), 0);

        // R7/R8 hold policy across two frames, then release
        cfg_div = 12'd0; cfg_dly_cs_sck = 8'd1; cfg_dly_sck_cs = 8'd1;
        cfg_dly_inter_cs = 8'd1; cfg_dly_frame_gap = 8'd1;
        cfg_cs_id = 5'd0; cfg_cs_mode = 2'd2;
        push(EV_CS, 14, -1, -1, "R7");
        push_edges(2, 1, 0, 0, 4, "R5");
        push_edges(2, 1, 0, 0, 6, "R7");
        base = frames_done;
        pulse_req();
        wait (frames_done == base + 1);
        pulse_req();
        wait (frames_done == base + 2);
        repeat (20) @(negedge clk);
        chk(cs_lines == 4'hE, "R7", int'(cs_lines), 14);
        @(negedge clk);
        push(EV_CS, 15, -1, cyc + 1 + 3, "R8");
        cfg_cs_mode = 2'd0;
        drain(10);

        // R9 off policy: clocks run, lines stay put
        cfg_div = 12'd1; cfg_cs_mode = 2'd3; cfg_cs_id = 5'd2;
        push_edges(2, 2, 0, 0, -1, "R9");
        base = frames_done;
        pulse_req();
        wait (frames_done == base + 1);
        drain(20);
        chk(cs_lines == 4'hF, "R9", int'(cs_lines), 15);

        // R10 out-of-range index selects nothing
        cfg_cs_mode = 2'd0; cfg_cs_id = 5'd6;
        push_edges(2, 2, 0, 0, -1, "R10");
        base = frames_done;
        pulse_req();
        wait (frames_done == base + 1);
        drain(20);
        chk(cs_lines == 4'hF, "R10", int'(cs_lines), 15);

        chk(q.size() == 0, "R2 scoreboard empty", q.size(), 0);
        summary();
    end
endmodule